// File: doc/BRIEF.md
# Twelve-Hour Timekeeping Counter

This block keeps wall-clock time as hours, minutes and seconds on a dial that wraps every twelve hours. Its single clock is the 32.768 kHz timebase. An internal prescaler counts that clock and issues a one-cycle enable once per second. The seconds, minutes and hours counters step on that enable, so the design has only one clock domain and no divided clock.

Each time field is presented as two packed BCD digits, ready for a display driver to scan. A half-second phase flag is high for the first half of every second and low for the second half, which gives a 1 Hz blink. A synchronous, active-high push-button reset clears the prescaler and loads 12:00:00.

The prescaler width is a parameter. The default of 15 bits divides the clock by 32768. A small width lets a full twelve-hour cycle be exercised in a short run.

Top module: `twelve_hour_clock`

## Requirements
- R1: When `rst` is high at a rising clock edge, the outputs after that edge are hours 8'h12, minutes 8'h00 and seconds 8'h00, and the prescaler count is zero, so `half_phase` is high.
- R2: After reset is released, the time advances by exactly one second every 2**PRESCALE_W clock cycles. The first advance happens at the 2**PRESCALE_W-th rising edge after release, and the outputs do not change on any other edge.
- R3: Seconds count from 00 to 59. The step after 59 is 00, and that step carries into minutes.
- R4: Minutes count from 00 to 59 and change only on a seconds carry. The step after 59 is 00, and that step carries into hours.
- R5: Hours count from 01 to 12 and change only on a minutes carry. The step after 12 is 01, and hours never show 00.
- R6: Every time output is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. The units digit is never above 9.
- R7: `half_phase` is high while the prescaler count is below 2**(PRESCALE_W-1) and low for the rest of each second, giving a 50 % duty cycle.
- R8: While `rst` stays high, the time stays at 12:00:00 no matter how many second periods pass. Counting restarts from a zero prescaler after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, 32.768 kHz in use |
| rst | input | 1 | Synchronous active-high reset from the push-button |
| hours_bcd | output | 8 | Hours 01..12 as packed BCD |
| minutes_bcd | output | 8 | Minutes 00..59 as packed BCD |
| seconds_bcd | output | 8 | Seconds 00..59 as packed BCD |
| half_phase | output | 1 | High during the first half of each second |

## Verification
The assertions check four things on every cycle:
- each field holds valid BCD and the hour stays within 01..12;
- all fields hold still between second enables;
- each field takes its correct next value, or wraps, when its enable is present;
- the blink flag rises exactly after an enable.

They also check that reset always loads 12:00:00. Properties cannot show the absolute schedule: that the n-th second lands on the right clock edge, and that a full twelve-hour cycle passes through every value in order. The bench shows these with a one-bit prescaler, sweeping more than twelve hours and comparing each cycle against time computed arithmetically from the number of edges since reset. A scenario that holds reset across several seconds shows R8.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

  typedef logic [7:0] bcd2_t;

  localparam int NUM_FIELDS = 3;

  // field order: 0 = seconds, 1 = minutes, 2 = hours
  localparam bcd2_t FIELD_LO  [NUM_FIELDS] = '{8'h00, 8'h00, 8'h01};
  localparam bcd2_t FIELD_HI  [NUM_FIELDS] = '{8'h59, 8'h59, 8'h12};
  localparam bcd2_t FIELD_INI [NUM_FIELDS] = '{8'h00, 8'h00, 8'h12};

  // next value of a two-digit BCD number, without range wrap
  function automatic bcd2_t bcd_step(input bcd2_t v);
    bcd2_t r;
    if (v[3:0] >= 4'd9) begin
      r[7:4] = v[7:4] + 4'd1;
      r[3:0] = 4'd0;
    end else begin
      r[7:4] = v[7:4];
      r[3:0] = v[3:0] + 4'd1;
    end
    return r;
  endfunction

  // next value within [lo, hi], wrapping hi -> lo
  function automatic bcd2_t bcd_wrap_step(input bcd2_t v, input bcd2_t lo, input bcd2_t hi);
    return (v == hi) ? lo : bcd_step(v);
  endfunction

  function automatic logic bcd_ok(input bcd2_t v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRESCALE_W = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  sec_tick,
  output logic                  first_half,
  output logic [PRESCALE_W-1:0] count
);

  localparam logic [PRESCALE_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  assign sec_tick   = (count == LAST);
  assign first_half = ~count[PRESCALE_W-1];

endmodule

// File: rtl/bcd_field_counter.sv
module bcd_field_counter
  import clk12_pkg::*;
#(
  parameter bcd2_t LO  = 8'h00,
  parameter bcd2_t HI  = 8'h59,
  parameter bcd2_t INI = 8'h00
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step_en,
  output bcd2_t value,
  output logic  carry
);

  always_ff @(posedge clk) begin
    if (rst)          value <= INI;
    else if (step_en) value <= bcd_wrap_step(value, LO, HI);
  end

  assign carry = step_en && (value == HI);

endmodule

// File: rtl/twelve_hour_clock.sv
module twelve_hour_clock
  import clk12_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] hours_bcd,
  output logic [7:0] minutes_bcd,
  output logic [7:0] seconds_bcd,
  output logic       half_phase
);

  logic                  sec_tick;
  logic [PRESCALE_W-1:0] presc_count;
  logic [NUM_FIELDS:0]   step_chain;
  bcd2_t                 field_val [NUM_FIELDS];

  // named events for the checker
  logic sec_wrap, min_wrap, dial_wrap;

  tick_prescaler #(.PRESCALE_W(PRESCALE_W)) u_presc (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .first_half (half_phase),
    .count      (presc_count)
  );

  assign step_chain[0] = sec_tick;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    bcd_field_counter #(
      .LO  (FIELD_LO[gi]),
      .HI  (FIELD_HI[gi]),
      .INI (FIELD_INI[gi])
    ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .step_en (step_chain[gi]),
      .value   (field_val[gi]),
      .carry   (step_chain[gi+1])
    );
  end

  assign sec_wrap  = step_chain[1];
  assign min_wrap  = step_chain[2];
  assign dial_wrap = step_chain[3];

  assign seconds_bcd = field_val[0];
  assign minutes_bcd = field_val[1];
  assign hours_bcd   = field_val[2];

endmodule

// File: rtl/twelve_hour_clock_checker.sv
module twelve_hour_clock_checker
  import clk12_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] hours_bcd,
  input logic [7:0] minutes_bcd,
  input logic [7:0] seconds_bcd,
  input logic       half_phase,
  input logic       sec_tick,
  input logic       sec_wrap,
  input logic       min_wrap,
  input logic       dial_wrap
);

  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> (hours_bcd == 8'h12 && minutes_bcd == 8'h00 && seconds_bcd == 8'h00 && half_phase));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ($stable(seconds_bcd) && $stable(minutes_bcd) && $stable(hours_bcd)));

  p_sec_step_r3: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> seconds_bcd == bcd_wrap_step($past(seconds_bcd), 8'h00, 8'h59));

  p_min_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !sec_wrap) |=> $stable(minutes_bcd));

  p_min_step_r4: assert property (@(posedge clk) disable iff (rst)
    sec_wrap |=> minutes_bcd == bcd_wrap_step($past(minutes_bcd), 8'h00, 8'h59));

  p_hour_step_r5: assert property (@(posedge clk) disable iff (rst)
    min_wrap |=> hours_bcd == bcd_wrap_step($past(hours_bcd), 8'h01, 8'h12));

  p_dial_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    dial_wrap |=> hours_bcd == 8'h01);

  p_hour_range_r5: assert property (@(posedge clk) disable iff (rst)
    hours_bcd != 8'h00 && hours_bcd <= 8'h12);

  p_bcd_digits_r6: assert property (@(posedge clk) disable iff (rst)
    bcd_ok(hours_bcd) && bcd_ok(minutes_bcd) && bcd_ok(seconds_bcd));

  p_half_rise_r7: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> half_phase);

  p_half_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(half_phase) |-> !$past(sec_tick));

endmodule

bind twelve_hour_clock twelve_hour_clock_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .hours_bcd   (hours_bcd),
  .minutes_bcd (minutes_bcd),
  .seconds_bcd (seconds_bcd),
  .half_phase  (half_phase),
  .sec_tick    (sec_tick),
  .sec_wrap    (sec_wrap),
  .min_wrap    (min_wrap),
  .dial_wrap   (dial_wrap)
);

// File: tb/twelve_hour_clock_bench.sv
module twelve_hour_clock_bench;

  localparam int W      = 1;
  localparam int PER    = 1 << W;
  localparam int HALFP  = PER / 2;
  localparam int DIAL_S = 12 * 3600;
  localparam int LIMIT  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hours_bcd, minutes_bcd, seconds_bcd;
  logic       half_phase;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  twelve_hour_clock #(.PRESCALE_W(W)) u_twelve_hour_clock (
    .clk         (clk),
    .rst         (rst),
    .hours_bcd   (hours_bcd),
    .minutes_bcd (minutes_bcd),
    .seconds_bcd (seconds_bcd),
    .half_phase  (half_phase)
  );

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare outputs against time derived from k edges since reset release
  task automatic check_at(input int k);
    int el, hi;
    el = k / PER;
    hi = (el / 3600) % 12;
    check("R2/R3 seconds", seconds_bcd, to_bcd(el % 60));
    check("R4 minutes",    minutes_bcd, to_bcd((el / 60) % 60));
    check("R5 hours",      hours_bcd,   to_bcd(hi == 0 ? 12 : hi));
    check("R7 half_phase", {7'd0, half_phase}, {7'd0, (k % PER) < HALFP});
    check("R6 units digits", {4'd0, (seconds_bcd[3:0] > 4'd9) || (minutes_bcd[3:0] > 4'd9)
                                   || (hours_bcd[3:0] > 4'd9)}, 8'd0);
  endtask

  task automatic reset_state(input string tag);
    check(tag, seconds_bcd, 8'h00);
    check(tag, minutes_bcd, 8'h00);
    check(tag, hours_bcd,   8'h12);
    check(tag, {7'd0, half_phase}, 8'd1);
  endtask

  initial begin : watchdog
    wait (cyc >= LIMIT);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_state("R1 reset load");
    rst = 1'b0;
    check_at(0);
    // full twelve-hour sweep plus margin past the dial wrap
    for (int k = 1; k <= (DIAL_S + 3700) * PER; k++) begin
      @(negedge clk);
      check_at(k);
    end
    // reset asserted mid-run and held for several seconds
    rst = 1'b1;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      reset_state("R8 reset held");
    end
    rst = 1'b0;
    check_at(0);
    for (int k = 1; k <= 200 * PER; k++) begin
      @(negedge clk);
      check_at(k);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule